// File: doc/BRIEF.md
# Watchpoint and Breakpoint Unit

This unit sits beside a processor core and observes two buses without ever stalling them: the instruction fetch address, and the load/store address and data. Eight programmable comparators check these buses in every cycle. Four watch the fetch address, two watch the load/store address and two watch the load/store data. Each comparator holds a reference value, an enable bit and a condition (equal, not equal, unsigned less than, unsigned greater than).

Comparator results feed six watchpoint outputs. Two neighbouring fetch comparators can be merged with AND or OR to form an address range. A load/store address comparator can be qualified by its partner data comparator. Any of four breakpoint channels can pick one of five watch sources and count its occurrences. The channel raises a one-cycle breakpoint pulse on the Nth occurrence, then starts counting again.

Configuration goes through a simple write port. A word address selects a register and `cfg_wdata` carries the value.

Top module: `dbg_trig_unit`

## Requirements
- R1: Comparators 0 to 3 test `if_addr` only while `if_valid` is high. Comparators 4 and 5 test `ls_addr`, and 6 and 7 test `ls_data`, only while `ls_valid` is high. Reference values are written at `cfg_addr` 0 to 7. The control word of comparator k is written at `cfg_addr` 8+k: bit 0 is the enable and bits 2:1 are the condition.
- R2: Condition code 0 matches when the bus equals the reference, 1 when they differ, 2 when the bus is below the reference and 3 when the bus is above it. Codes 2 and 3 treat both operands as unsigned.
- R3: A comparator whose enable bit is clear never matches, whatever its condition and reference value.
- R4: `wp_o` shows the watch results one clock after the bus cycle. A bus whose valid strobe is low produces no watch event.
- R5: The combine register is at `cfg_addr` 16. Bits 1:0 set the mode of fetch pair (0,1) and bits 3:2 set the mode of fetch pair (2,3). Mode 0 reports each comparator on its own pin, `wp_o[2p]` and `wp_o[2p+1]`. Mode 1 drives `wp_o[2p]` with the AND of the pair. Mode 2 drives `wp_o[2p]` with the OR of the pair. In every mode `wp_o[2p+1]` shows the upper comparator alone.
- R6: Bits 5:4 of the combine register set the mode of `wp_o[4]`, which uses comparators 4 and 6. Bits 7:6 set the mode of `wp_o[5]`, which uses comparators 5 and 7. Mode 0 uses the address comparator only, mode 1 the AND of address and data, mode 2 their OR, and mode 3 the data comparator only.
- R7: Breakpoint channel b is configured at `cfg_addr` 20+b. Bit 0 is the enable and bits 3:1 select the source: values 0 to 3 pick `wp_o` bit 0 to 3, value 4 picks the OR of `wp_o` bits 4 and 5, and values 5 to 7 pick nothing. A disabled channel, or one with no source, never fires.
- R8: Bits 31:16 of the channel word hold the count N. The channel pulses `bkpt_hit[b]` for one cycle on the Nth source event, in the same cycle as the matching `wp_o` update, and then reloads N. A count of 0 acts as 1. Writing the channel word restarts the count.
- R9: `bkpt_req` is high in exactly the cycles where any `bkpt_hit` bit is high.
- R10: After reset every register is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid | input | 1 | Fetch address valid |
| if_addr | input | 32 | Fetch address |
| ls_valid | input | 1 | Load/store cycle valid |
| ls_addr | input | 32 | Load/store address |
| ls_data | input | 32 | Load/store data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| wp_o | output | 6 | Watchpoint event pins |
| bkpt_hit | output | 4 | Per-channel breakpoint pulses |
| bkpt_req | output | 1 | Breakpoint request |

## Verification
The assertions run on every cycle. They check four things: an idle bus produces no watch event on its pins, a disabled comparator in separate mode keeps its pin low, a breakpoint pulse always follows a source event on an enabled channel, and a channel's counter never exceeds its reload value. Other behaviour only shows up in the scenarios. This covers the unsigned edges of the less-than and greater-than conditions, every pair and qualification mode, the exact occurrence on which a breakpoint fires, the count-of-zero case, and restarting the count by rewriting the channel.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

    localparam int N_CMP  = 8;
    localparam int N_WP   = 6;
    localparam int N_BP   = 4;
    localparam int N_SRC  = 5;
    localparam int REG_AW = 5;

    // configuration map
    localparam logic [REG_AW-1:0] A_CTRL_BASE = 5'd8;
    localparam logic [REG_AW-1:0] A_COMBINE   = 5'd16;
    localparam logic [2:0]        A_BP_GROUP  = 3'b101;

    typedef enum logic [1:0] {
        OP_EQ = 2'd0,
        OP_NE = 2'd1,
        OP_LT = 2'd2,
        OP_GT = 2'd3
    } cmp_op_e;

    typedef struct packed {
        cmp_op_e op;
        logic    en;
    } cmp_ctrl_t;

    typedef enum logic [1:0] {
        PM_SEP = 2'd0,
        PM_AND = 2'd1,
        PM_OR  = 2'd2,
        PM_RSV = 2'd3
    } pair_mode_e;

    typedef enum logic [1:0] {
        QM_ADDR = 2'd0,
        QM_AND  = 2'd1,
        QM_OR   = 2'd2,
        QM_DATA = 2'd3
    } qual_mode_e;

    function automatic logic pair_mix(pair_mode_e m, logic lo, logic hi);
        case (m)
            PM_AND:  return lo & hi;
            PM_OR:   return lo | hi;
            default: return lo;
        endcase
    endfunction

    function automatic logic qual_mix(qual_mode_e m, logic a, logic d);
        case (m)
            QM_AND:  return a & d;
            QM_OR:   return a | d;
            QM_DATA: return d;
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/dtu_cmp.sv
module dtu_cmp
    import dtu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            valid,
    input  logic [W-1:0]    operand,
    input  logic [W-1:0]    ref_val,
    input  cmp_ctrl_t       ctrl,
    output logic            hit
);
    logic rel;

    always_comb begin
        case (ctrl.op)
            OP_EQ:   rel = (operand == ref_val);
            OP_NE:   rel = (operand != ref_val);
            OP_LT:   rel = (operand <  ref_val);
            default: rel = (operand >  ref_val);
        endcase
        hit = valid & ctrl.en & rel;
    end
endmodule

// File: rtl/dtu_watch_net.sv
module dtu_watch_net
    import dtu_pkg::*;
(
    input  logic [N_CMP-1:0] cmp_hit,
    input  logic [7:0]       combine,
    output logic [N_WP-1:0]  wp
);
    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_fetch_pair
            assign wp[2*p]   = pair_mix(pair_mode_e'(combine[2*p +: 2]),
                                        cmp_hit[2*p], cmp_hit[2*p+1]);
            assign wp[2*p+1] = cmp_hit[2*p+1];
        end
        for (p = 0; p < 2; p++) begin : g_ls_pair
            assign wp[4+p] = qual_mix(qual_mode_e'(combine[4+2*p +: 2]),
                                      cmp_hit[4+p], cmp_hit[6+p]);
        end
    endgenerate
endmodule

// File: rtl/dtu_bkpt_ctr.sv
module dtu_bkpt_ctr
    import dtu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              wr_en,
    input  logic [2:0]        wr_src,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic [N_SRC-1:0]  src_vec,
    output logic              bp_o
);
    logic             en_q;
    logic [2:0]       src_q;
    logic [CNT_W-1:0] reload_q, cnt_q, eff_reload, eff_new;
    logic             src_hit, fire;

    assign eff_reload = (reload_q == '0) ? CNT_W'(1) : reload_q;
    assign eff_new    = (wr_count == '0) ? CNT_W'(1) : wr_count;
    assign src_hit    = (src_q < 3'(N_SRC)) ? src_vec[src_q] : 1'b0;
    assign fire       = !wr && en_q && src_hit && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            src_q    <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
            bp_o     <= 1'b0;
        end else begin
            bp_o <= fire;
            if (wr) begin
                en_q     <= wr_en;
                src_q    <= wr_src;
                reload_q <= wr_count;
                cnt_q    <= eff_new;
            end else if (en_q && src_hit) begin
                cnt_q <= fire ? eff_reload : cnt_q - CNT_W'(1);
            end
        end
    end

    AST_BP_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        bp_o |-> $past(en_q && src_hit && !wr)) else $error("bp without event"); // R8
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= eff_reload) else $error("count above reload"); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (bp_o && eff_reload > CNT_W'(1) && !wr) |=> !bp_o) else $error("pulse too long"); // R8
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dtu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              if_valid,
    input  logic [AW-1:0]     if_addr,
    input  logic              ls_valid,
    input  logic [AW-1:0]     ls_addr,
    input  logic [DW-1:0]     ls_data,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [N_WP-1:0]   wp_o,
    output logic [N_BP-1:0]   bkpt_hit,
    output logic              bkpt_req
);
    localparam int VW = (AW > DW) ? AW : DW;

    logic [VW-1:0]    ref_q [N_CMP];
    cmp_ctrl_t        ctl_q [N_CMP];
    logic [7:0]       combine_q;
    logic [N_CMP-1:0] cmp_hit;
    logic [N_WP-1:0]  wp_now;
    logic [N_SRC-1:0] src_vec;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CMP; i++) begin
                ref_q[i] <= '0;
                ctl_q[i] <= '0;
            end
            combine_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr < A_CTRL_BASE)
                ref_q[cfg_addr[2:0]] <= VW'(cfg_wdata);
            else if (cfg_addr < A_COMBINE)
                ctl_q[cfg_addr[2:0]] <= cmp_ctrl_t'(cfg_wdata[2:0]);
            else if (cfg_addr == A_COMBINE)
                combine_q <= cfg_wdata[7:0];
        end
    end

    // comparator bank, split by observed bus
    genvar k;
    generate
        for (k = 0; k < N_CMP; k++) begin : g_cmp
            logic          v;
            logic [VW-1:0] opd;
            if (k < 4) begin : g_if
                assign v   = if_valid;
                assign opd = VW'(if_addr);
            end else if (k < 6) begin : g_lsa
                assign v   = ls_valid;
                assign opd = VW'(ls_addr);
            end else begin : g_lsd
                assign v   = ls_valid;
                assign opd = VW'(ls_data);
            end
            dtu_cmp #(.W(VW)) i_cmp (
                .valid   (v),
                .operand (opd),
                .ref_val (ref_q[k]),
                .ctrl    (ctl_q[k]),
                .hit     (cmp_hit[k])
            );
        end
    endgenerate

    dtu_watch_net i_net (
        .cmp_hit (cmp_hit),
        .combine (combine_q),
        .wp      (wp_now)
    );

    assign src_vec = {wp_now[5] | wp_now[4], wp_now[3:0]};

    always_ff @(posedge clk) begin
        if (rst) wp_o <= '0;
        else     wp_o <= wp_now;
    end

    generate
        for (k = 0; k < N_BP; k++) begin : g_bp
            logic sel;
            assign sel = cfg_we && (cfg_addr[4:2] == A_BP_GROUP)
                                && (cfg_addr[1:0] == 2'(k));
            dtu_bkpt_ctr #(.CNT_W(CNT_W)) i_ctr (
                .clk      (clk),
                .rst      (rst),
                .wr       (sel),
                .wr_en    (cfg_wdata[0]),
                .wr_src   (cfg_wdata[3:1]),
                .wr_count (cfg_wdata[16 +: CNT_W]),
                .src_vec  (src_vec),
                .bp_o     (bkpt_hit[k])
            );
        end
    endgenerate

    assign bkpt_req = |bkpt_hit;

    AST_IF_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !if_valid |=> (wp_o[3:0] == '0)) else $error("fetch event while idle"); // R4
    AST_LS_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ls_valid |=> (wp_o[5:4] == '0)) else $error("ls event while idle"); // R4
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q[0].en && combine_q[1:0] == 2'd0) |=> !wp_o[0]) else $error("disabled cmp hit"); // R3
endmodule

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        if_valid = 1'b0, ls_valid = 1'b0, cfg_we = 1'b0;
    logic [31:0] if_addr = '0, ls_addr = '0, ls_data = '0, cfg_wdata = '0;
    logic [4:0]  cfg_addr = '0;
    logic [5:0]  wp_o;
    logic [3:0]  bkpt_hit;
    logic        bkpt_req;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [5:0] wp;
        logic [3:0] bp;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trig_unit i_dbg_trig_unit (
        .clk(clk), .rst(rst),
        .if_valid(if_valid), .if_addr(if_addr),
        .ls_valid(ls_valid), .ls_addr(ls_addr), .ls_data(ls_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .wp_o(wp_o), .bkpt_hit(bkpt_hit), .bkpt_req(bkpt_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        if_valid = 1'b0; ls_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    endtask

    task automatic set_cmp(int idx, logic [31:0] val, logic en, logic [1:0] op);
        wr(5'(idx), val);
        wr(5'(8 + idx), {29'd0, op, en});
    endtask

    // driver: drive one bus cycle and queue the expected result
    task automatic step(logic iv, logic [31:0] ia, logic lv, logic [31:0] la,
                        logic [31:0] ld, logic [5:0] ewp, logic [3:0] ebp, string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b0;
        if_valid = iv; if_addr = ia;
        ls_valid = lv; ls_addr = la; ls_data = ld;
        e.wp = ewp; e.bp = ebp; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_we = 1'b0; if_valid = 1'b0; ls_valid = 1'b0;
    endtask

    // monitor: results appear one edge after the driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " wp"},  32'(wp_o), 32'(e.wp));
                check({e.tag, " bp"},  32'(bkpt_hit), 32'(e.bp));
                check("R9 req", 32'(bkpt_req), 32'(|e.bp));
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R10 reset wp", 32'(wp_o), 32'd0);
        check("R10 reset bp", 32'(bkpt_hit), 32'd0);
        check("R10 reset req", 32'(bkpt_req), 32'd0);

        // R1 R2: four fetch comparators, each condition
        set_cmp(0, 32'h100, 1'b1, 2'd0);
        set_cmp(1, 32'h200, 1'b1, 2'd1);
        set_cmp(2, 32'h8000_0000, 1'b1, 2'd2);
        set_cmp(3, 32'h10, 1'b1, 2'd3);
        step(1, 32'h100, 0, 0, 0, 6'h0F, 4'h0, "R1 R2 eq");
        step(1, 32'h200, 0, 0, 0, 6'h0C, 4'h0, "R2 ne-miss");
        step(1, 32'hFFFF_FFF0, 0, 0, 0, 6'h0A, 4'h0, "R2 unsigned lt");
        step(1, 32'h10, 0, 0, 0, 6'h06, 4'h0, "R2 gt-equal");
        step(0, 32'h100, 1, 32'h100, 0, 6'h00, 4'h0, "R4 R1 idle fetch");
        set_cmp(1, 32'h200, 1'b0, 2'd1);
        step(1, 32'h100, 0, 0, 0, 6'h0D, 4'h0, "R3 disabled");

        // R5: fetch pairs
        set_cmp(0, 32'h1000, 1'b1, 2'd3);
        set_cmp(1, 32'h2000, 1'b1, 2'd2);
        wr(5'd16, 32'h1);
        step(1, 32'h1800, 0, 0, 0, 6'h0F, 4'h0, "R5 and in");
        step(1, 32'h2800, 0, 0, 0, 6'h0C, 4'h0, "R5 and out");
        wr(5'd16, 32'h2);
        step(1, 32'h2800, 0, 0, 0, 6'h0D, 4'h0, "R5 or lo");
        step(1, 32'h0800, 0, 0, 0, 6'h0F, 4'h0, "R5 or hi");
        wr(5'd16, 32'h6);
        step(1, 32'h0800, 0, 0, 0, 6'h0F, 4'h0, "R5 pair1 and");
        step(1, 32'h8, 0, 0, 0, 6'h03, 4'h0, "R5 pair1 and miss");

        // R6: load/store qualification
        for (int i = 0; i < 4; i++) wr(5'(8 + i), 32'h0);
        set_cmp(4, 32'h4000, 1'b1, 2'd0);
        set_cmp(6, 32'hAB, 1'b1, 2'd0);
        wr(5'd16, 32'h00);
        step(0, 0, 1, 32'h4000, 32'h0, 6'h10, 4'h0, "R6 addr only");
        wr(5'd16, 32'h10);
        step(0, 0, 1, 32'h4000, 32'h0, 6'h00, 4'h0, "R6 and miss");
        step(0, 0, 1, 32'h4000, 32'hAB, 6'h10, 4'h0, "R6 and hit");
        wr(5'd16, 32'h20);
        step(0, 0, 1, 32'h5000, 32'hAB, 6'h10, 4'h0, "R6 or data");
        step(0, 0, 1, 32'h5000, 32'h0, 6'h00, 4'h0, "R6 or none");
        wr(5'd16, 32'h30);
        step(0, 0, 1, 32'h4000, 32'h0, 6'h00, 4'h0, "R6 data only miss");
        step(0, 0, 1, 32'h5000, 32'hAB, 6'h10, 4'h0, "R6 data only hit");
        step(0, 0, 0, 32'h5000, 32'hAB, 6'h00, 4'h0, "R4 ls idle");
        set_cmp(5, 32'h100, 1'b1, 2'd3);
        set_cmp(7, 32'h0, 1'b1, 2'd1);
        wr(5'd16, 32'h70);
        step(0, 0, 1, 32'h4000, 32'hAB, 6'h30, 4'h0, "R6 both");
        step(0, 0, 1, 32'h4000, 32'h0, 6'h00, 4'h0, "R6 both miss");

        // R7 R8 R9: breakpoint channels
        set_cmp(0, 32'h100, 1'b1, 2'd0);
        wr(5'd16, 32'h40);
        wr(5'd20, (32'd3 << 16) | (32'd0 << 1) | 32'd1);
        wr(5'd21, (32'd1 << 16) | (32'd4 << 1) | 32'd1);
        wr(5'd22, (32'd1 << 16) | (32'd5 << 1) | 32'd1);
        wr(5'd23, (32'd1 << 16) | (32'd0 << 1) | 32'd0);
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h0, "R8 occ1");
        step(1, 32'h104, 0, 0, 0, 6'h00, 4'h0, "R8 miss no count");
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h0, "R8 occ2");
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h1, "R8 R7 occ3 fire");
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h0, "R8 reload 1");
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h0, "R8 reload 2");
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h1, "R8 reload fire");
        step(1, 32'h100, 1, 32'h4000, 0, 6'h11, 4'h2, "R7 src4");
        step(1, 32'h100, 1, 32'h4000, 0, 6'h11, 4'h2, "R7 src4 again");
        step(1, 32'h100, 1, 32'h4000, 0, 6'h11, 4'h3, "R9 two channels");
        wr(5'd20, (32'd0 << 16) | 32'd1);
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h1, "R8 zero count");
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h1, "R8 zero count back");
        wr(5'd20, (32'd2 << 16) | 32'd1);
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h0, "R8 pre-restart");
        wr(5'd20, (32'd2 << 16) | 32'd1);
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h0, "R8 restarted");
        step(1, 32'h100, 0, 0, 0, 6'h01, 4'h1, "R8 restart fire");
        idle();
        repeat (3) @(negedge clk);
        check("scoreboard drained", 32'(sb_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule